// File: doc/BRIEF.md
# I2C Master Byte Command Engine

This block drives an I2C bus as a single master, one byte at a time, under the control of software. Software loads a transmit byte, then writes a command word. The command word is a set of request bits: generate a start condition, send the buffered byte, receive a byte (optionally the last one, answered with NACK), and generate a stop condition. Any combination may be requested in one write. The engine performs the requested phases in a fixed order and clears each request bit as its phase completes.

Results are posted in a status register whose bits are cleared by writing ones to them. An enable register uses the same bit positions, and a single interrupt line is raised while any enabled status bit is set. Sequencing across multiple bytes and messages is left to the interrupt handler.

The SCL and SDA outputs are open-drain pull requests. The engine waits while a target stretches SCL and gives up after a programmable timeout. It reports lost arbitration, a timeout, or an illegal command by flushing every pending request and releasing the bus.

Top module: `i2c_byte_master`

## Requirements
- R1: After reset, both pull outputs are inactive, the interrupt is low and every register reads zero.
- R2: While the control register's enable bit (register 0, bit 0) is clear, command writes are ignored: the command register keeps reading zero and no bus activity occurs.
- R3: Command bits are bit 0 start, bit 1 transmit, bit 3 receive, bit 4 last receive and bit 5 stop. Their phases run in the order start, transmit, receive, stop. Each pending bit clears when its phase ends. The command register (register 3) shows the pending bits in 5:0 and the bus-held flag in bit 16.
- R4: A transmit phase sends buffer bits 7:0 MSB first. It then sets status bit 0 if the target acknowledged, or status bit 1 if it did not.
- R5: A receive phase places the byte in buffer bits 15:8 (register 4) and sets status bit 2. It acknowledges the byte, or answers NACK when the last-receive bit was set.
- R6: When start, transmit and receive are requested together, status bit 2 appears only after the data byte, never at the end of the address byte.
- R7: A stop phase generates a stop condition, releases both lines, clears the bus-held flag and sets status bit 4.
- R8: If SDA is released but sampled low during a transmitted bit, status bit 3 is set, all pending requests are discarded and both lines are released.
- R9: If released SCL stays low for the timeout length, status bit 6 is set, all pending requests are discarded and both lines are released.
- R10: A transmit, receive or stop request without start, while the bus is not held, sets status bit 5 and is discarded.
- R11: Writing a 1 to a status bit (register 2) clears it, and writing a 0 leaves it unchanged.
- R12: The interrupt output is high exactly when some status bit and the same bit of the enable register (register 1) are both set.
- R13: SDA changes only while SCL is low, except for start and stop conditions.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index: 0 control, 1 enable, 2 status, 3 command, 4 buffer |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| scl_in | input | 1 | Sampled SCL line |
| sda_in | input | 1 | Sampled SDA line |
| scl_pull | output | 1 | Pull SCL low when high |
| sda_pull | output | 1 | Pull SDA low when high |
| irq | output | 1 | Interrupt request |

## Verification
The assertions watch the following rules on every cycle:
- command writes are ignored while the engine is disabled;
- a lost arbitration or a timeout leaves no pending request and no line pulled;
- a full status clear while idle empties the status register;
- SDA stays steady through the high half of each data bit.

Only the bench scenarios can show the rest, because these depend on the byte values a responding target sees and returns:
- that bytes reach the target MSB first;
- that a read ends with NACK only when the last-receive bit was set;
- that a chained start, transmit and receive reports receive-done only after the data byte;
- that start and stop conditions occur exactly as often as requested.

// File: rtl/i2c_byte_master.sv
module i2c_byte_master #(
  parameter int QDIV = 8,
  parameter int TMO  = 4096
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [31:0] reg_rdata,
  input  logic        scl_in,
  input  logic        sda_in,
  output logic        scl_pull,
  output logic        sda_pull,
  output logic        irq
);
  localparam int QW = (QDIV > 2) ? $clog2(QDIV) : 1;
  localparam int TW = (TMO > 2) ? $clog2(TMO) : 1;
  localparam logic [2:0] A_CTRL = 3'd0, A_IEN = 3'd1, A_STS = 3'd2, A_CMD = 3'd3, A_BUF = 3'd4;
  localparam int C_START = 0, C_TX = 1, C_RX = 3, C_LAST = 4, C_STOP = 5;

  typedef enum logic [1:0] {P_IDLE, P_START, P_BYTE, P_STOP} phase_t;

  phase_t       phase;
  logic [1:0]   q;
  logic [QW-1:0] qcnt;
  logic [TW-1:0] tcnt;
  logic [3:0]   bitn;
  logic [7:0]   shreg, txb, rxb;
  logic [6:0]   ien, sts, sset;
  logic [5:0]   cmd;
  logic         en, owned, is_tx, is_last, scl_drv, sda_drv;

  logic tick, wait_hi, blocked, adv, cmd_wr, abn, arb, tmo, flush, byte_end, sts_wr;

  assign tick     = (qcnt == QW'(QDIV - 1));
  assign wait_hi  = (phase == P_START && q == 2'd1) || (phase == P_BYTE && q == 2'd2) ||
                    (phase == P_STOP && q == 2'd1);
  assign blocked  = wait_hi && !scl_in;
  assign adv      = tick && !blocked;
  assign cmd_wr   = reg_we && reg_addr == A_CMD && en && phase == P_IDLE && cmd == 6'd0;
  assign abn      = cmd_wr && !reg_wdata[C_START] && !owned &&
                    (reg_wdata[C_TX] || reg_wdata[C_RX] || reg_wdata[C_STOP]);
  assign byte_end = phase == P_BYTE && q == 2'd3 && adv && bitn == 4'd8;
  assign arb      = phase == P_BYTE && q == 2'd3 && adv && bitn < 4'd8 && is_tx && !sda_drv && !sda_in;
  assign tmo      = blocked && tcnt == TW'(TMO - 1);
  assign flush    = arb || tmo;
  assign sts_wr   = reg_we && reg_addr == A_STS;

  assign sset = {tmo, abn, phase == P_STOP && q == 2'd3 && adv, arb,
                 byte_end && !is_tx, byte_end && is_tx && sda_in, byte_end && is_tx && !sda_in};

  assign scl_pull = scl_drv;
  assign sda_pull = sda_drv;
  assign irq      = |(sts & ien);

  always_comb begin
    case (reg_addr)
      A_CTRL:  reg_rdata = {31'd0, en};
      A_IEN:   reg_rdata = {25'd0, ien};
      A_STS:   reg_rdata = {25'd0, sts};
      A_CMD:   reg_rdata = {15'd0, owned, 10'd0, cmd};
      A_BUF:   reg_rdata = {16'd0, rxb, txb};
      default: reg_rdata = 32'd0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en <= 1'b0; ien <= '0; txb <= '0; sts <= '0;
    end else begin
      if (reg_we && reg_addr == A_CTRL) en <= reg_wdata[0];
      if (reg_we && reg_addr == A_IEN)  ien <= reg_wdata[6:0];
      if (reg_we && reg_addr == A_BUF)  txb <= reg_wdata;
      sts <= (sts & ~(sts_wr ? reg_wdata[6:0] : 7'd0)) | sset;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      qcnt <= '0; tcnt <= '0;
    end else begin
      if (phase == P_IDLE || adv || flush) qcnt <= '0;
      else if (!tick) qcnt <= qcnt + QW'(1);
      if (blocked && !flush) tcnt <= tcnt + TW'(1);
      else tcnt <= '0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= P_IDLE; q <= '0; bitn <= '0; shreg <= '0; rxb <= '0; cmd <= '0;
      owned <= 1'b0; is_tx <= 1'b0; is_last <= 1'b0; scl_drv <= 1'b0; sda_drv <= 1'b0;
    end else if (flush) begin
      phase <= P_IDLE; q <= '0; cmd <= '0; owned <= 1'b0; scl_drv <= 1'b0; sda_drv <= 1'b0;
    end else if (cmd_wr) begin
      if (!abn) cmd <= reg_wdata[5:0] & 6'b111011;
    end else begin
      case (phase)
        P_IDLE: if (en && cmd != 6'd0) begin
          q <= '0;
          if (cmd[C_START]) begin
            phase <= P_START;
            sda_drv <= 1'b0;
          end else if (cmd[C_TX] || cmd[C_RX]) begin
            phase <= P_BYTE;
            bitn <= '0;
            is_tx <= cmd[C_TX];
            is_last <= cmd[C_LAST];
            shreg <= cmd[C_TX] ? txb : 8'd0;
            scl_drv <= 1'b1;
          end else begin
            phase <= P_STOP;
            scl_drv <= 1'b1;
            sda_drv <= 1'b1;
          end
        end
        P_START: if (adv) begin
          q <= q + 2'd1;
          case (q)
            2'd0: scl_drv <= 1'b0;
            2'd1: sda_drv <= 1'b1;
            2'd2: scl_drv <= 1'b1;
            default: begin
              owned <= 1'b1;
              cmd[C_START] <= 1'b0;
              phase <= P_IDLE;
            end
          endcase
        end
        P_BYTE: if (adv) begin
          q <= q + 2'd1;
          case (q)
            2'd0: sda_drv <= (bitn < 4'd8) ? (is_tx && !shreg[7]) : (!is_tx && !is_last);
            2'd1: scl_drv <= 1'b0;
            2'd2: ;
            default: begin
              scl_drv <= 1'b1;
              shreg <= {shreg[6:0], sda_in};
              if (bitn == 4'd8) begin
                phase <= P_IDLE;
                if (is_tx) cmd[C_TX] <= 1'b0;
                else begin
                  cmd[C_RX] <= 1'b0;
                  cmd[C_LAST] <= 1'b0;
                  rxb <= shreg;
                end
              end else bitn <= bitn + 4'd1;
            end
          endcase
        end
        P_STOP: if (adv) begin
          q <= q + 2'd1;
          case (q)
            2'd0: scl_drv <= 1'b0;
            2'd1: sda_drv <= 1'b0;
            2'd2: ;
            default: begin
              owned <= 1'b0;
              cmd[C_STOP] <= 1'b0;
              phase <= P_IDLE;
            end
          endcase
        end
        default: phase <= P_IDLE;
      endcase
    end
  end

  // R2
  disabled_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_addr == A_CMD && !en) |=> cmd == $past(cmd));

  // R8
  arb_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[3]) |-> (cmd == 6'd0 && !scl_pull && !sda_pull));

  // R9
  tmo_flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(sts[6]) |-> (cmd == 6'd0 && !scl_pull && !sda_pull));

  // R11
  w1c_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sts_wr && reg_wdata[6:0] == 7'h7f && phase == P_IDLE) |=> sts == 7'd0);

  // R13
  sda_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (phase == P_BYTE && q == 2'd3) |-> $stable(sda_pull));
endmodule

// File: tb/i2c_byte_master_tb.sv
module i2c_byte_master_tb_top;
  localparam int CLK_P = 10;
  localparam logic [6:0] SADDR = 7'h50;

  logic clk = 1'b0, rst_n = 1'b0, reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic scl_pull, sda_pull, irq;
  logic tb_scl_low = 1'b0, tb_sda_low = 1'b0, slv_sda_low = 1'b0;
  wire scl = !(scl_pull || tb_scl_low);
  wire sda = !(sda_pull || tb_sda_low || slv_sda_low);

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #(CLK_P/2) clk = ~clk;

  i2c_byte_master #(.QDIV(4), .TMO(64)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .scl_in(scl), .sda_in(sda), .scl_pull(scl_pull), .sda_pull(sda_pull),
    .irq(irq));

  // Behavioural target: decodes start/stop, acknowledges its address, logs writes, serves reads.
  logic [7:0] wr_q[$], rd_q[$];
  bit mack_q[$];
  int n_start = 0, n_stop = 0, mode = 0, cnt = 0;
  logic [7:0] sr = '0, ob = '0;
  logic pscl = 1'b1, psda = 1'b1, rw = 1'b0, mack = 1'b0;

  always @(negedge clk) begin
    pscl <= scl; psda <= sda;
    if (rst_n) begin
      if (pscl && scl && psda && !sda) begin
        n_start <= n_start + 1; mode <= 1; cnt <= 0; slv_sda_low <= 1'b0;
      end else if (pscl && scl && !psda && sda) begin
        n_stop <= n_stop + 1; mode <= 0; slv_sda_low <= 1'b0;
      end else if (!pscl && scl && mode >= 1 && mode <= 3) begin
        if (cnt < 8) begin
          sr <= {sr[6:0], sda}; cnt <= cnt + 1;
        end else if (cnt == 8) begin
          mack <= !sda; cnt <= 9;
          if (mode == 3) mack_q.push_back(!sda);
        end
      end else if (pscl && !scl && mode >= 1 && mode <= 3) begin
        if (cnt == 8) begin
          if (mode == 1) begin
            if (sr[7:1] == SADDR) begin slv_sda_low <= 1'b1; rw <= sr[0]; end
            else mode <= 0;
          end else if (mode == 2) begin
            wr_q.push_back(sr); slv_sda_low <= 1'b1;
          end else slv_sda_low <= 1'b0;
        end else if (cnt == 9) begin
          cnt <= 0;
          if ((mode == 1 && rw) || (mode == 3 && mack)) begin
            logic [7:0] b;
            b = (rd_q.size() > 0) ? rd_q.pop_front() : 8'hFF;
            ob <= b; slv_sda_low <= !b[7]; mode <= 3;
          end else if (mode == 1) begin
            mode <= 2; slv_sda_low <= 1'b0;
          end else if (mode == 2) slv_sda_low <= 1'b0;
          else begin slv_sda_low <= 1'b0; mode <= 4; end
        end else if (mode == 3 && cnt >= 1 && cnt <= 7) begin
          slv_sda_low <= !ob[7 - cnt];
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_we = 1'b1;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); reg_addr = a; #1 d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] v;
    for (int i = 0; i < 5000; i++) begin
      rd(3'd3, v);
      if (v[5:0] == 6'd0) break;
    end
  endtask

  task automatic wait_irq();
    for (int i = 0; i < 5000; i++) begin
      @(negedge clk);
      if (irq) break;
    end
  endtask

  initial begin
    repeat (15000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, s;
    int st0, sp0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int a = 0; a < 5; a++) begin
      rd(3'(a), v); chk(v == 0, "R1 register after reset", v, 0);
    end
    chk(!scl_pull && !sda_pull && !irq, "R1 outputs after reset", {scl_pull, sda_pull, irq}, 0);

    // R2 disabled engine ignores commands
    wr(3'd4, 8'hA0); wr(3'd3, 8'h03);
    repeat (60) @(negedge clk);
    rd(3'd3, v); chk(v == 0, "R2 command while disabled", v, 0);
    chk(n_start == 0 && !scl_pull, "R2 no bus activity", n_start, 0);

    wr(3'd0, 8'h01); wr(3'd1, 8'h7F);

    // R4 address write acknowledged
    wr(3'd3, 8'h03); wait_irq();
    rd(3'd2, v); chk(v == 32'h01, "R4 address ACK status", v, 32'h01);
    rd(3'd3, v); chk(v == 32'h10000, "R3 start+tx cleared, bus held", v, 32'h10000);
    wr(3'd2, 8'h01);
    rd(3'd2, v); chk(v == 0 && !irq, "R11 W1C clear", {irq, v[30:0]}, 0);

    // R4 data byte MSB first
    wr(3'd4, 8'h5A); wr(3'd3, 8'h02); wait_irq();
    rd(3'd2, v); chk(v == 32'h01, "R4 data ACK status", v, 32'h01);
    chk(wr_q.size() == 1 && wr_q[0] == 8'h5A, "R4 target got byte", wr_q.size() ? wr_q[0] : 0, 8'h5A);
    wr(3'd2, 8'h7F);

    // R7 stop
    sp0 = n_stop;
    wr(3'd3, 8'h20); wait_irq();
    rd(3'd2, v); chk(v == 32'h10, "R7 stop status", v, 32'h10);
    chk(n_stop == sp0 + 1 && !scl_pull && !sda_pull, "R7 stop seen, lines free", n_stop, sp0 + 1);
    rd(3'd3, v); chk(v == 0, "R7 bus not held", v, 0);
    wr(3'd2, 8'h7F);

    // R4 NAK on unknown address, combined with stop
    wr(3'd4, 8'h66); wr(3'd3, 8'h23); wait_idle();
    rd(3'd2, v); chk(v == 32'h12, "R4 NAK then stop", v, 32'h12);
    wr(3'd2, 8'h7F);

    // R6 / R5 / R3 chained read with last byte and stop in one write
    rd_q.push_back(8'hC3);
    wr(3'd4, 8'hA1); wr(3'd3, 8'h3B);
    s = 0;
    for (int i = 0; i < 3000 && s == 0; i++) rd(3'd2, s);
    chk(s == 32'h01, "R6 only TX status after address", s, 32'h01);
    rd(3'd3, v); chk(v[5:0] == 6'h38, "R3 remaining pending bits", v[5:0], 6'h38);
    wait_idle();
    rd(3'd2, v); chk(v == 32'h15, "R3 all phases done", v, 32'h15);
    rd(3'd4, v); chk(v[15:8] == 8'hC3, "R5 received byte", v[15:8], 8'hC3);
    chk(mack_q.size() > 0 && mack_q[$] == 1'b0, "R5 NACK on last", mack_q.size() ? mack_q[$] : 1'bx, 0);
    wr(3'd2, 8'h7F);

    // R5 two-byte read: ACK on first, NACK on last
    rd_q.push_back(8'h81); rd_q.push_back(8'h7E);
    wr(3'd3, 8'h0B); wait_idle();
    rd(3'd2, v); chk(v == 32'h05, "R5 first byte status", v, 32'h05);
    rd(3'd4, v); chk(v[15:8] == 8'h81, "R5 first byte", v[15:8], 8'h81);
    chk(mack_q[$] == 1'b1, "R5 ACK on non-last", mack_q[$], 1);
    wr(3'd2, 8'h7F);
    wr(3'd3, 8'h38); wait_idle();
    rd(3'd2, v); chk(v == 32'h14, "R5 last byte status", v, 32'h14);
    rd(3'd4, v); chk(v[15:8] == 8'h7E, "R5 last byte", v[15:8], 8'h7E);
    chk(mack_q[$] == 1'b0, "R5 NACK on last", mack_q[$], 0);
    wr(3'd2, 8'h7F);

    // R13 no spurious start/stop from data changes
    chk(n_start == 4 && n_stop == 4, "R13 start/stop count", {n_start[15:0], n_stop[15:0]}, 32'h00040004);

    // R10 abnormal command
    st0 = n_start;
    wr(3'd3, 8'h02); repeat (20) @(negedge clk);
    rd(3'd2, v); chk(v == 32'h20, "R10 abnormal status", v, 32'h20);
    rd(3'd3, v); chk(v == 0 && n_start == st0, "R10 command discarded", v, 0);

    // R12 interrupt gating, R11 zero write keeps bit
    wr(3'd1, 8'h00); chk(!irq, "R12 masked", irq, 0);
    wr(3'd1, 8'h20); chk(irq, "R12 enabled", irq, 1);
    wr(3'd2, 8'h00); rd(3'd2, v); chk(v == 32'h20, "R11 zero write no effect", v, 32'h20);
    wr(3'd2, 8'h20); chk(!irq, "R12 cleared", irq, 0);
    wr(3'd1, 8'h7F);

    // R8 arbitration loss
    tb_sda_low = 1'b1;
    wr(3'd4, 8'hA0); wr(3'd3, 8'h23); wait_irq();
    rd(3'd2, v); chk(v == 32'h08, "R8 arbitration status", v, 32'h08);
    rd(3'd3, v); chk(v == 0 && !scl_pull && !sda_pull, "R8 flushed", v, 0);
    tb_sda_low = 1'b0; repeat (10) @(negedge clk);
    wr(3'd2, 8'h7F);

    // R9 SCL timeout
    tb_scl_low = 1'b1;
    wr(3'd3, 8'h03); wait_irq();
    rd(3'd2, v); chk(v == 32'h40, "R9 timeout status", v, 32'h40);
    rd(3'd3, v); chk(v == 0 && !scl_pull && !sda_pull, "R9 flushed", v, 0);
    tb_scl_low = 1'b0;
    wr(3'd2, 8'h7F);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule